// File: doc/BRIEF.md
# Timer Match and External-Output Unit

This block is a free-running timer with four compare channels. A prescale counter divides the clock. Each time it wraps, the timer count advances by one, as long as the run bit is set. Each compare channel holds a match value, and the channel fires on an advance where the current count equals that value. When a channel fires, it can restart the count, halt the count, or do both. It also drives an external output pin, whose level is its status flag. The pin action on a match is one of hold, clear, set or toggle.

Software configures the block through a plain register write strobe. It reads the block back through a combinational read port. Writing the external-control register forces every pin to a defined level at once, with no match needed.

Top module: `tmr_match_unit`

## Requirements
- R1: After reset every register reads 0, all four pins are low, and the count does not move.
- R2: Register map (4-bit address): 0 run bit in bit 0; 1 prescale limit; 2 match control (restart bits [3:0], halt bits [7:4], one per channel); 3 external control; 4 timer count; 5 prescale count (read only); 8 to 11 match values of channels 0 to 3. All written fields read back.
- R3: While run is 1, the prescale count goes 0 up to the limit and wraps to 0. The timer count advances by one on each wrap, so it advances once every limit+1 cycles. Writing address 4 loads the timer count and clears the prescale count.
- R4: On an advance where the count equals a channel's match value and its restart bit is 1, the count becomes 0 instead of advancing.
- R5: On an advance where the count equals a channel's match value and its halt bit is 1, the run bit clears and the count holds that value.
- R6: When the restart and halt bits of one channel are both 1, its match clears the count and leaves it halted at 0.
- R7: The external control register has a 2-bit action field per channel at bits [5:4], [7:6], [9:8] and [11:10] for channels 0 to 3. Code 00 holds the pin on a match, 01 drives it to 0, 10 drives it to 1, and 11 inverts it. Bits [3:0] read back the current pin levels.
- R8: A write to the external control register sets every pin at once. With action 01 the pin goes to 0, with 10 it goes to 1, and with 00 or 11 it takes the written bit [i].
- R9: Bits above bit 11 of the external control register and above bit 7 of the match control register read as 0, and writes to them have no effect.
- R10: A channel fires at most once per advance. A count that is held by a slow prescaler gives a single pin toggle.
- R11: A register write in the same cycle as a match takes priority over it. An external control write sets the pins from the written data, and a run-bit write sets the run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| ext_match | output | 4 | External match pins, one per channel |

## Verification
Two functions can act in the same cycle: a channel's match event, and a software write to the register that the match would update. The bench counts clock edges from the run-bit write so that a write of the external control register, or of the run bit, lands on the exact edge where a match fires. It then checks that the pin shows the written level and not the toggle, and that the run bit stays set despite a halt match. A restart and a halt on the same channel also fire together, and the bench checks that the count settles at 0 with the run bit low.

// File: rtl/tmr_pkg.sv
// Shared definitions for the timer match unit: register addresses and
// the pin action encoding with its two update rules.
// Assumes a 4-bit register address space.
package tmr_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_CLR  = 2'b01,
        ACT_SET  = 2'b10,
        ACT_TGL  = 2'b11
    } act_e;

    localparam int ADR_CTL  = 0;
    localparam int ADR_PRE  = 1;
    localparam int ADR_MCTL = 2;
    localparam int ADR_EXT  = 3;
    localparam int ADR_TC   = 4;
    localparam int ADR_PC   = 5;
    localparam int ADR_MR0  = 8;

    // Pin level after a match event under action a.
    function automatic logic pin_on_match(act_e a, logic cur);
        unique case (a)
            ACT_HOLD: return cur;
            ACT_CLR:  return 1'b0;
            ACT_SET:  return 1'b1;
            default:  return ~cur;
        endcase
    endfunction

    // Pin level forced by a write of action a with data bit d.
    function automatic logic pin_on_write(act_e a, logic d);
        unique case (a)
            ACT_CLR: return 1'b0;
            ACT_SET: return 1'b1;
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
// Prescale divider: counts 0..limit while run is high and pulses tick
// on the wrap cycle. Assumes limit may be rewritten at any time; a count
// above a lowered limit wraps on its next step.
module tmr_prescaler #(
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic [PW-1:0] limit,
    output logic [PW-1:0] pc,
    output logic          tick
);

    // Wrap pulse: the count has reached the limit while running.
    assign tick = run && (pc >= limit);

    // Prescale count: clear, wrap or step.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc <= '0;
        else if (clr)    pc <= '0;
        else if (tick)   pc <= '0;
        else if (run)    pc <= pc + PW'(1);
    end

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(pc));
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pc == '0));

endmodule

// File: rtl/tmr_counter.sv
// Timer count with per-channel compare. A channel fires on a prescaler
// tick when the current count equals its match value. A restart
// overrides a halt, and a halt overrides the step. A software load
// overrides everything.
module tmr_counter #(
    parameter int TW   = 32,
    parameter int N_CH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     ld,
    input  logic [TW-1:0]            ld_val,
    input  logic [N_CH-1:0][TW-1:0]  mr,
    input  logic [N_CH-1:0]          rst_en,
    input  logic [N_CH-1:0]          stop_en,
    output logic [TW-1:0]            tc,
    output logic [N_CH-1:0]          hit,
    output logic                     stop_req
);

    logic any_rst;

    // Compare per channel, qualified by the advance tick.
    for (genvar i = 0; i < N_CH; i++) begin : g_cmp
        assign hit[i] = tick && (tc == mr[i]);
    end

    assign any_rst  = |(hit & rst_en);
    assign stop_req = |(hit & stop_en);

    // Timer count update by priority: load, restart, halt, step.
    always_ff @(posedge clk) begin
        if (!rst_n)        tc <= '0;
        else if (ld)       tc <= ld_val;
        else if (any_rst)  tc <= '0;
        else if (stop_req) tc <= tc;
        else if (tick)     tc <= tc + TW'(1);
    end

    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (any_rst && !ld) |=> (tc == '0));
    a_r5_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !any_rst && !ld) |=> $stable(tc));
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hit == '0 && !ld) |=> (tc == $past(tc) + TW'(1)));
    a_r10_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld) |=> $stable(tc));

endmodule

// File: rtl/tmr_ext_pin.sv
// One external match pin with its flag. A register write sets the level
// from the new action and the data bit. Otherwise a match applies the
// stored action. The write takes priority.
module tmr_ext_pin
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  act_e act,
    input  logic wr,
    input  act_e wr_act,
    input  logic wr_bit,
    output logic pin
);

    // Pin level update: write first, then match event.
    always_ff @(posedge clk) begin
        if (!rst_n)   pin <= 1'b0;
        else if (wr)  pin <= pin_on_write(wr_act, wr_bit);
        else if (hit) pin <= pin_on_match(act, pin);
    end

    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !hit) |=> $stable(pin));
    a_r8_force_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_act == ACT_CLR) |=> !pin);
    a_r11_write_first: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit && wr_act == ACT_SET) |=> pin);

endmodule

// File: rtl/tmr_match_unit.sv
// Top: register file, prescaler, timer count and per-channel pins.
// Assumes TW and PW are not larger than DW, and 3*N_CH <= DW.
// Reads are combinational from rd_addr.
module tmr_match_unit
    import tmr_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int TW   = 32,
    parameter int PW   = 32,
    parameter int AW   = 4,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic [N_CH-1:0] ext_match
);

    localparam int ECW = 2 * N_CH;
    localparam int EXW = 3 * N_CH;

    logic                    run_q;
    logic [PW-1:0]           pre_q;
    logic [N_CH-1:0]         rst_en_q, stop_en_q;
    logic [ECW-1:0]          ext_ctl_q;
    logic [N_CH-1:0][TW-1:0] mr_q;
    logic [TW-1:0]           tc;
    logic [PW-1:0]           pc;
    logic                    tick, stop_req;
    logic [N_CH-1:0]         hit;
    logic wr_ctl, wr_pre, wr_mctl, wr_ext, wr_tc;

    assign wr_ctl  = wr_en && (wr_addr == AW'(ADR_CTL));
    assign wr_pre  = wr_en && (wr_addr == AW'(ADR_PRE));
    assign wr_mctl = wr_en && (wr_addr == AW'(ADR_MCTL));
    assign wr_ext  = wr_en && (wr_addr == AW'(ADR_EXT));
    assign wr_tc   = wr_en && (wr_addr == AW'(ADR_TC));

    // Run bit: software write wins, otherwise a halt match clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= 1'b0;
        else if (wr_ctl)   run_q <= wr_data[0];
        else if (stop_req) run_q <= 1'b0;
    end

    // Configuration registers; only defined fields are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q     <= '0;
            rst_en_q  <= '0;
            stop_en_q <= '0;
            ext_ctl_q <= '0;
        end else begin
            if (wr_pre)  pre_q <= wr_data[PW-1:0];
            if (wr_mctl) begin
                rst_en_q  <= wr_data[N_CH-1:0];
                stop_en_q <= wr_data[ECW-1:N_CH];
            end
            if (wr_ext)  ext_ctl_q <= wr_data[EXW-1:N_CH];
        end
    end

    // Match value registers, one per channel.
    for (genvar i = 0; i < N_CH; i++) begin : g_mr
        logic wr_mr;
        assign wr_mr = wr_en && (wr_addr == AW'(ADR_MR0 + i));
        always_ff @(posedge clk) begin
            if (!rst_n)     mr_q[i] <= '0;
            else if (wr_mr) mr_q[i] <= wr_data[TW-1:0];
        end
    end

    tmr_prescaler #(.PW(PW)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .clr   (wr_tc),
        .limit (pre_q),
        .pc    (pc),
        .tick  (tick)
    );

    tmr_counter #(.TW(TW), .N_CH(N_CH)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ld       (wr_tc),
        .ld_val   (wr_data[TW-1:0]),
        .mr       (mr_q),
        .rst_en   (rst_en_q),
        .stop_en  (stop_en_q),
        .tc       (tc),
        .hit      (hit),
        .stop_req (stop_req)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_pin
        tmr_ext_pin u_pin (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (hit[i]),
            .act    (act_e'(ext_ctl_q[2*i +: 2])),
            .wr     (wr_ext),
            .wr_act (act_e'(wr_data[N_CH + 2*i +: 2])),
            .wr_bit (wr_data[i]),
            .pin    (ext_match[i])
        );
    end

    // Read multiplexer, zero-filled above each field.
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            AW'(ADR_CTL):  rd_data[0] = run_q;
            AW'(ADR_PRE):  rd_data[PW-1:0] = pre_q;
            AW'(ADR_MCTL): rd_data[ECW-1:0] = {stop_en_q, rst_en_q};
            AW'(ADR_EXT):  rd_data[EXW-1:0] = {ext_ctl_q, ext_match};
            AW'(ADR_TC):   rd_data[TW-1:0] = tc;
            AW'(ADR_PC):   rd_data[PW-1:0] = pc;
            default: begin
                for (int i = 0; i < N_CH; i++)
                    if (rd_addr == AW'(ADR_MR0 + i)) rd_data[TW-1:0] = mr_q[i];
            end
        endcase
    end

    a_r5_halt_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !wr_ctl) |=> !run_q);
    a_r11_run_write_first: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wr_data[0]) |=> run_q);
    a_r1_halted_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !tick);
    a_r6_both_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hit & rst_en_q & stop_en_q) && !wr_tc && !wr_ctl) |=> (tc == '0 && !run_q));

endmodule

// File: tb/tmr_match_unit_tb.sv
module tmr_match_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  ext_match;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_match_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_match(ext_match)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at a negedge; the write lands on the next posedge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Stop, configure and start; run is set on the edge E of the last write.
    task automatic setup(input logic [31:0] pre, input logic [31:0] mctl,
                         input logic [31:0] ext, input logic [31:0] m0,
                         input logic [31:0] m1, input logic [31:0] m2,
                         input logic [31:0] m3);
        wr(4'd0, 32'd0);
        wr(4'd1, pre);
        wr(4'd2, mctl);
        wr(4'd3, ext);
        wr(4'd8, m0); wr(4'd9, m1); wr(4'd10, m2); wr(4'd11, m3);
        wr(4'd4, 32'd0);
        wr(4'd0, 32'd1);
    endtask

    localparam logic [31:0] FAR = 32'hFFFF_FF00;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R1: reset state of every register and pin
        for (int a = 0; a < 12; a++) begin
            if (a == 6 || a == 7) continue;
            rd(4'(a), v);
            chk("R1 reset reg", v, 32'd0);
        end
        chk("R1 pins", {28'd0, ext_match}, 32'd0);
        repeat (5) step();
        rd(4'd4, v); chk("R1 count idle", v, 32'd0);

        // R2: readback of written fields
        wr(4'd1, 32'h0000_1234); rd(4'd1, v); chk("R2 prescale", v, 32'h0000_1234);
        for (int i = 0; i < 4; i++) begin
            wr(4'(8 + i), 32'hA5A5_0000 + 32'(i));
            rd(4'(8 + i), v); chk("R2 match value", v, 32'hA5A5_0000 + 32'(i));
        end
        wr(4'd2, 32'h0000_005A); rd(4'd2, v); chk("R2 match control", v, 32'h0000_005A);
        wr(4'd4, 32'd77); rd(4'd4, v); chk("R2 count load", v, 32'd77);

        // R9: reserved bits read 0 and writes are dropped
        wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, v); chk("R9 match control reserved", v, 32'h0000_00FF);
        wr(4'd3, 32'hFFFF_FFFF); rd(4'd3, v); chk("R9 ext reserved", v, 32'h0000_0FFF);
        wr(4'd3, 32'd0); wr(4'd2, 32'd0);

        // R3: prescale sweep, count and prescale count every cycle
        for (int p = 0; p < 4; p++) begin
            setup(32'(p), 32'd0, 32'd0, FAR, FAR, FAR, FAR);
            for (int m = 1; m <= 20; m++) begin
                step();
                rd(4'd4, v); chk("R3 count", v, 32'(m / (p + 1)));
                rd(4'd5, v); chk("R3 prescale count", v, 32'(m % (p + 1)));
            end
        end

        // R4: restart sweep on channel 0
        for (int mv = 0; mv < 5; mv++) begin
            setup(32'd0, 32'h0000_0001, 32'd0, 32'(mv), FAR, FAR, FAR);
            for (int m = 1; m <= 20; m++) begin
                step();
                rd(4'd4, v); chk("R4 restart count", v, 32'(m % (mv + 1)));
            end
        end

        // R5: halt sweep on channel 1 (halt bit 5)
        for (int mv = 0; mv < 5; mv++) begin
            setup(32'd0, 32'h0000_0020, 32'd0, FAR, 32'(mv), FAR, FAR);
            for (int m = 1; m <= 10; m++) begin
                step();
                rd(4'd4, v); chk("R5 halt count", v, 32'((m < mv) ? m : mv));
                rd(4'd0, v); chk("R5 run bit", v, 32'((m < mv + 1) ? 1 : 0));
            end
        end

        // R6: restart and halt together on channel 2 (bits 2 and 6)
        for (int mv = 1; mv < 4; mv++) begin
            setup(32'd0, 32'h0000_0044, 32'd0, FAR, FAR, 32'(mv), FAR);
            for (int m = 1; m <= 8; m++) begin
                step();
                rd(4'd4, v); chk("R6 count", v, 32'((m <= mv) ? m : 0));
                rd(4'd0, v); chk("R6 run bit", v, 32'((m < mv + 1) ? 1 : 0));
            end
        end

        // R8: write forcing per action code with both data levels
        for (int c = 0; c < 4; c++) begin
            for (int d = 0; d < 2; d++) begin
                logic [3:0] ep;
                logic [31:0] w;
                w = {20'd0, {4{2'(c)}}, {4{1'(d)}}};
                ep = (c == 1) ? 4'h0 : (c == 2) ? 4'hF : {4{1'(d)}};
                wr(4'd3, w);
                chk("R8 forced pins", {28'd0, ext_match}, {28'd0, ep});
                rd(4'd3, v); chk("R7 pin readback", v, {w[31:4], ep});
            end
        end

        // R7: toggle on match per channel, others hold, with restart
        for (int ch = 0; ch < 4; ch++) begin
            for (int mv = 1; mv < 4; mv++) begin
                logic [31:0] ext, mctl;
                logic [3:0] base;
                base = 4'b1010;
                ext = {20'd0, 8'd0, base} | (32'h3 << (4 + 2 * ch));
                mctl = 32'd1 << ch;
                setup(32'd0, mctl, ext, (ch == 0) ? 32'(mv) : 32'd0,
                      (ch == 1) ? 32'(mv) : 32'd0, (ch == 2) ? 32'(mv) : 32'd0,
                      (ch == 3) ? 32'(mv) : 32'd0);
                for (int m = 1; m <= 3 * (mv + 1) + 2; m++) begin
                    logic [3:0] ep;
                    step();
                    ep = base;
                    ep[ch] = base[ch] ^ 1'((m / (mv + 1)) & 1);
                    chk("R7 toggle pins", {28'd0, ext_match}, {28'd0, ep});
                end
            end
        end

        // R7: cleared and set levels persist through matches
        setup(32'd0, 32'h0000_0001, 32'h0000_0090, 32'd1, 32'd0, 32'd0, 32'd0);
        for (int m = 1; m <= 8; m++) begin
            step();
            chk("R7 clear/set persist", {28'd0, ext_match}, 32'h0000_0002);
        end

        // R10: slow prescaler, held count toggles once
        setup(32'd3, 32'd0, 32'h0000_0030, 32'd2, FAR, FAR, FAR);
        for (int m = 1; m <= 40; m++) begin
            step();
            chk("R10 single toggle", {31'd0, ext_match[0]}, 32'((m >= 12) ? 1 : 0));
        end

        // R11: ext write on the exact match edge wins over the toggle
        setup(32'd0, 32'h0000_0001, 32'h0000_0030, 32'd3, FAR, FAR, FAR);
        repeat (3) step();
        wr(4'd3, 32'h0000_0010);
        chk("R11 ext write over match", {31'd0, ext_match[0]}, 32'd0);
        repeat (4) step();
        chk("R11 later match holds clear", {31'd0, ext_match[0]}, 32'd0);

        // R11: run write on the exact halt edge wins
        setup(32'd0, 32'h0000_0020, 32'd0, FAR, 32'd2, FAR, FAR);
        repeat (2) step();
        wr(4'd0, 32'd1);
        rd(4'd0, v); chk("R11 run write over halt", v, 32'd1);
        rd(4'd4, v2); chk("R11 count held", v2, 32'd2);
        step();
        rd(4'd0, v); chk("R11 next match halts", v, 32'd0);
        rd(4'd4, v2); chk("R11 count still held", v2, 32'd2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule